// File: doc/BRIEF.md
# Structure Load/Store Micro-op Sequencer

This block sits in the decode stage of a vector core. It takes one 32-bit vector structure load or store instruction word and breaks it into an ordered stream of micro-ops, one per handshake on its output side. Two sideband inputs come with the word. One says whether the word is a store. The other says whether the offset is a scalar register or a signed immediate. The block pulls out the register, predicate and size fields. It checks that the encoding is legal and scales the immediate by the number of registers in the structure. It then issues twice as many micro-ops as there are registers.

A load first moves memory into N temporary registers, one memory micro-op per slice. It then runs N deinterleave micro-ops that write the architectural vectors. A store runs the other way: N interleave micro-ops fill the temporaries, then N memory store micro-ops drain them. An illegal word yields a single "undefined" micro-op. The sequencer holds one instruction at a time. It accepts a new word only while idle and moves forward by one micro-op on every cycle in which the consumer is ready.

Top module: `struct_ldst_seq`

## Requirements
- R1: Every micro-op carries these fields of the accepted word unchanged:
  - first vector register, bits 4:0
  - base register, bits 9:5
  - predicate, bits 12:10
  - offset register field, bits 20:16
  - element size code, bits 24:23, where codes 0..3 mean 8, 16, 32 and 64-bit elements
- R2: The register count N is the count code in bits 22:21 plus one. A count code of 0 makes the word illegal. An illegal word produces exactly one micro-op with op code 0 (undefined), register 0, temporary flag 0, slice 0 and register count 0.
- R3: When `in_imm_form` is 0 (register offset form), an offset register field of 31 makes the word illegal, with the same single undefined micro-op as R2. In the immediate form the value 31 is legal.
- R4: When `in_imm_form` is 1, `uop_imm` carries bits 19:16 sign-extended from 4 bits and multiplied by N (with N = code+1), as a 7-bit two's complement value. When `in_imm_form` is 0, `uop_imm` is 0.
- R5: A legal word with N registers produces exactly 2N micro-ops. After the micro-op flagged last is taken, `uop_valid` is low on the next cycle.
- R6: A load (`in_store` = 0) issues these micro-ops in order:
  - slices 0..N-1 as op 1 (memory load) with temporary flag 1 and register = slice
  - then slices 0..N-1 as op 4 (deinterleave) with temporary flag 0 and register = first vector register + slice
- R7: A store (`in_store` = 1) issues these micro-ops in order, all with temporary flag 1 and register = slice:
  - slices 0..N-1 as op 3 (interleave)
  - then slices 0..N-1 as op 2 (memory store)
- R8: The architectural register of a deinterleave micro-op is taken modulo 32, so the register list wraps from 31 to 0.
- R9: Only the first micro-op of an instruction has `uop_first` high, and only the final one has `uop_last` high. `uop_defer` (delayed commit) is high on every micro-op except the last.
- R10: `in_ready` is high only while no instruction is in progress, so a word offered while busy is ignored. While `uop_ready` is low the presented micro-op holds steady. One micro-op is taken per cycle in which `uop_valid` and `uop_ready` are both high.
- R11: After reset `in_ready` is 1 and `uop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Sequencer idle, word will be taken |
| in_word | input | 32 | Instruction word |
| in_store | input | 1 | 1 = store, 0 = load |
| in_imm_form | input | 1 | 1 = immediate offset form, 0 = register offset form |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | 0 undefined, 1 memory load, 2 memory store, 3 interleave, 4 deinterleave |
| uop_tmp | output | 1 | Register index names a temporary |
| uop_reg | output | 5 | Destination register index |
| uop_slice | output | 2 | Slice index within the structure |
| uop_nregs | output | 3 | Register count N (0 when undefined) |
| uop_first | output | 1 | First micro-op of the instruction |
| uop_last | output | 1 | Last micro-op of the instruction |
| uop_defer | output | 1 | Delayed commit |
| uop_vfirst | output | 5 | First vector register field |
| uop_base | output | 5 | Base register field |
| uop_offreg | output | 5 | Offset register field |
| uop_pred | output | 3 | Predicate field |
| uop_esize | output | 2 | Element size code |
| uop_imm | output | 7 | Scaled immediate |

## Verification
The hardest situation to reach from the ports is a word offered while a long structure is still stalled mid-stream. The stimulus stalls `uop_ready` on a rotating set of micro-op positions. During every stall it raises `in_valid` with a different word, so the bench can show that the stream and its fields do not move. The sweep crosses both directions and both offset forms with every count code, every immediate value, and offset fields that include 31. First registers of 30 and 31 are included so that the deinterleave list wraps past register 31 at every count.

// File: rtl/slq_pkg.sv
package slq_pkg;
    localparam int WORD_W    = 32;
    localparam int ARCH_REGS = 32;
    localparam int MAX_NREGS = 4;
    localparam int IMM_W     = 4;
    localparam int PRED_W    = 3;
    localparam int ESZ_W     = 2;
    localparam int CODE_W    = 2;

    localparam int REG_AW  = $clog2(ARCH_REGS);
    localparam int SLICE_W = $clog2(MAX_NREGS);
    localparam int CNT_W   = $clog2(MAX_NREGS + 1);
    localparam int STEP_W  = $clog2(2 * MAX_NREGS);
    localparam int SIMM_W  = IMM_W + CNT_W;

    // Field positions inside the instruction word
    localparam int F_VT_LO   = 0;
    localparam int F_BASE_LO = 5;
    localparam int F_PRED_LO = 10;
    localparam int F_OFF_LO  = 16;
    localparam int F_CNT_LO  = 21;
    localparam int F_ESZ_LO  = 23;

    typedef enum logic [2:0] {
        OP_UNDEF  = 3'd0,
        OP_MEM_LD = 3'd1,
        OP_MEM_ST = 3'd2,
        OP_ILV    = 3'd3,
        OP_DILV   = 3'd4
    } uop_op_e;

    typedef struct packed {
        logic              legal;
        logic              store;
        logic [CNT_W-1:0]  nregs;
        logic [REG_AW-1:0] vfirst;
        logic [REG_AW-1:0] base;
        logic [REG_AW-1:0] offreg;
        logic [PRED_W-1:0] pred;
        logic [ESZ_W-1:0]  esize;
        logic [SIMM_W-1:0] imm;
    } instr_t;

    typedef struct packed {
        uop_op_e            op;
        logic               tmp;
        logic [REG_AW-1:0]  regi;
        logic [SLICE_W-1:0] slice;
        logic [CNT_W-1:0]   nregs;
        logic               first;
        logic               last;
        logic               defer;
    } uop_t;

    // Index of the final micro-op of an instruction
    function automatic logic [STEP_W-1:0] last_step(input instr_t i);
        logic [CNT_W:0] dbl;
        dbl = {i.nregs, 1'b0} - (CNT_W+1)'(1);
        return i.legal ? STEP_W'(dbl) : '0;
    endfunction

    // Sign-extend the raw immediate, then multiply by the register count
    function automatic logic [SIMM_W-1:0] scale_imm(input logic [IMM_W-1:0] raw,
                                                    input logic [CNT_W-1:0] n);
        logic [SIMM_W-1:0] sx;
        logic [SIMM_W-1:0] nx;
        sx = {{(SIMM_W-IMM_W){raw[IMM_W-1]}}, raw};
        nx = {{(SIMM_W-CNT_W){1'b0}}, n};
        return sx * nx;
    endfunction
endpackage

// File: rtl/slq_decode.sv
module slq_decode
    import slq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              is_store,
    input  logic              imm_form,
    output instr_t            dec
);
    logic [CODE_W-1:0] cnt_code;
    logic [REG_AW-1:0] off_field;
    logic [IMM_W-1:0]  imm_raw;
    logic [CNT_W-1:0]  n;
    logic              off_bad;

    always_comb begin
        cnt_code  = word[F_CNT_LO +: CODE_W];
        off_field = word[F_OFF_LO +: REG_AW];
        imm_raw   = word[F_OFF_LO +: IMM_W];
        n         = CNT_W'(cnt_code) + CNT_W'(1);
        off_bad   = !imm_form && (off_field == REG_AW'(ARCH_REGS - 1));

        dec.legal  = (cnt_code != '0) && !off_bad;
        dec.store  = is_store;
        dec.nregs  = n;
        dec.vfirst = word[F_VT_LO   +: REG_AW];
        dec.base   = word[F_BASE_LO +: REG_AW];
        dec.offreg = off_field;
        dec.pred   = word[F_PRED_LO +: PRED_W];
        dec.esize  = word[F_ESZ_LO  +: ESZ_W];
        dec.imm    = imm_form ? scale_imm(imm_raw, n) : '0;
    end
endmodule

// File: rtl/slq_step.sv
module slq_step
    import slq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  instr_t            dec_in,
    input  logic              uop_ready,
    output instr_t            held,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              at_last
);
    always_comb begin
        at_last  = busy && (step == last_step(held));
        in_ready = !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            step <= '0;
            held <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                busy <= 1'b1;
                step <= '0;
                held <= dec_in;
            end
        end else if (uop_ready) begin
            if (at_last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/slq_uop_build.sv
module slq_uop_build
    import slq_pkg::*;
(
    input  instr_t            held,
    input  logic [STEP_W-1:0] step,
    input  logic              at_last,
    output uop_t              uop
);
    logic              second;
    logic [STEP_W-1:0] idx;

    always_comb begin
        second = step >= STEP_W'(held.nregs);
        idx    = second ? (step - STEP_W'(held.nregs)) : step;

        uop.first = (step == '0);
        uop.last  = at_last;
        uop.defer = !at_last;

        if (!held.legal) begin
            uop.op    = OP_UNDEF;
            uop.tmp   = 1'b0;
            uop.regi  = '0;
            uop.slice = '0;
            uop.nregs = '0;
        end else begin
            uop.slice = SLICE_W'(idx);
            uop.nregs = held.nregs;
            if (held.store) begin
                uop.op   = second ? OP_MEM_ST : OP_ILV;
                uop.tmp  = 1'b1;
                uop.regi = REG_AW'(idx);
            end else if (second) begin
                uop.op   = OP_DILV;
                uop.tmp  = 1'b0;
                // power-of-two register file: truncation gives the wrap
                uop.regi = held.vfirst + REG_AW'(idx);
            end else begin
                uop.op   = OP_MEM_LD;
                uop.tmp  = 1'b1;
                uop.regi = REG_AW'(idx);
            end
        end
    end
endmodule

// File: rtl/struct_ldst_seq.sv
module struct_ldst_seq
    import slq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic               in_store,
    input  logic               in_imm_form,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [2:0]         uop_op,
    output logic               uop_tmp,
    output logic [REG_AW-1:0]  uop_reg,
    output logic [SLICE_W-1:0] uop_slice,
    output logic [CNT_W-1:0]   uop_nregs,
    output logic               uop_first,
    output logic               uop_last,
    output logic               uop_defer,
    output logic [REG_AW-1:0]  uop_vfirst,
    output logic [REG_AW-1:0]  uop_base,
    output logic [REG_AW-1:0]  uop_offreg,
    output logic [PRED_W-1:0]  uop_pred,
    output logic [ESZ_W-1:0]   uop_esize,
    output logic [SIMM_W-1:0]  uop_imm
);
    instr_t            dec;
    instr_t            held;
    logic              busy;
    logic [STEP_W-1:0] step;
    logic              at_last;
    uop_t              uop;

    slq_decode u_dec (
        .word     (in_word),
        .is_store (in_store),
        .imm_form (in_imm_form),
        .dec      (dec)
    );

    slq_step u_step (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .dec_in    (dec),
        .uop_ready (uop_ready),
        .held      (held),
        .busy      (busy),
        .step      (step),
        .at_last   (at_last)
    );

    slq_uop_build u_build (
        .held    (held),
        .step    (step),
        .at_last (at_last),
        .uop     (uop)
    );

    always_comb begin
        uop_valid  = busy;
        uop_op     = uop.op;
        uop_tmp    = uop.tmp;
        uop_reg    = uop.regi;
        uop_slice  = uop.slice;
        uop_nregs  = uop.nregs;
        uop_first  = uop.first;
        uop_last   = uop.last;
        uop_defer  = uop.defer;
        uop_vfirst = held.vfirst;
        uop_base   = held.base;
        uop_offreg = held.offreg;
        uop_pred   = held.pred;
        uop_esize  = held.esize;
        uop_imm    = held.imm;
    end
endmodule

// File: rtl/slq_checker.sv
module slq_checker
    import slq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               uop_valid,
    input logic               uop_ready,
    input logic [2:0]         uop_op,
    input logic               uop_tmp,
    input logic [REG_AW-1:0]  uop_reg,
    input logic [SLICE_W-1:0] uop_slice,
    input logic [CNT_W-1:0]   uop_nregs,
    input logic               uop_first,
    input logic               uop_last,
    input logic               uop_defer
);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && uop_valid));

    a_r10_accept: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> uop_valid && uop_first);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_reg)
                                    && $stable(uop_slice) && $stable(uop_first)
                                    && $stable(uop_last));

    a_r5_end: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && uop_last |=> !uop_valid && in_ready);

    a_r9_middle: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && !uop_last |=> uop_valid && !uop_first && $past(uop_defer));

    a_r2_undef: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_op == 3'd0 |-> uop_first && uop_last && uop_nregs == '0);

    a_r6_tmp_dest: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_op == 3'd4 |-> !uop_tmp);

    a_r7_tmp_src: assert property (@(posedge clk) disable iff (rst)
        uop_valid && (uop_op == 3'd1 || uop_op == 3'd2 || uop_op == 3'd3) |-> uop_tmp);

    a_r5_slice_range: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_op != 3'd0 |-> CNT_W'(uop_slice) < uop_nregs);
endmodule

bind struct_ldst_seq slq_checker u_chk (.*);

// File: tb/tb_struct_ldst_seq.sv
`timescale 1ns/1ps
module tb_struct_ldst_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        in_store = 1'b0;
    logic        in_imm_form = 1'b0;
    logic        uop_valid;
    logic        uop_ready = 1'b1;
    logic [2:0]  uop_op;
    logic        uop_tmp;
    logic [4:0]  uop_reg;
    logic [1:0]  uop_slice;
    logic [2:0]  uop_nregs;
    logic        uop_first, uop_last, uop_defer;
    logic [4:0]  uop_vfirst, uop_base, uop_offreg;
    logic [2:0]  uop_pred;
    logic [1:0]  uop_esize;
    logic [6:0]  uop_imm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    struct_ldst_seq dut (.*);

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_uop(input bit st, input bit immf, input logic [31:0] w, input int k);
        int code, n, rm, vt, s, total, idx, e_op, e_reg, e_tmp, e_imm;
        bit legal, second;
        string rq;
        code  = int'(w[22:21]);
        n     = code + 1;
        rm    = int'(w[20:16]);
        vt    = int'(w[4:0]);
        legal = (code != 0) && (immf || rm != 31);
        total = legal ? 2 * n : 1;
        second = legal && (k >= n);
        idx   = second ? k - n : k;
        if (!legal) begin
            e_op = 0; e_reg = 0; e_tmp = 0; idx = 0;
            rq = (code == 0) ? "R2" : "R3";
        end else if (st) begin
            e_op = second ? 2 : 3; e_reg = idx; e_tmp = 1; rq = "R7";
        end else begin
            e_op = second ? 4 : 1; e_tmp = second ? 0 : 1;
            e_reg = second ? (vt + idx) % 32 : idx; rq = "R6";
        end
        s = int'(w[19:16]);
        if (s >= 8) s = s - 16;
        e_imm = immf ? ((s * n) & 127) : 0;

        chk(rq, "valid", int'(uop_valid), 1);
        chk(rq, "op", int'(uop_op), e_op);
        chk(rq, "tmp", int'(uop_tmp), e_tmp);
        chk(rq, "reg", int'(uop_reg), e_reg);
        chk(rq, "slice", int'(uop_slice), idx);
        if (legal && !st && second && (vt + idx) >= 32)
            chk("R8", "wrapped reg", int'(uop_reg), (vt + idx) - 32);
        chk("R2", "nregs", int'(uop_nregs), legal ? n : 0);
        chk("R4", "imm", int'(uop_imm), e_imm);
        chk("R9", "first", int'(uop_first), (k == 0) ? 1 : 0);
        chk("R9", "last", int'(uop_last), (k == total - 1) ? 1 : 0);
        chk("R9", "defer", int'(uop_defer), (k == total - 1) ? 0 : 1);
        chk("R1", "vfirst", int'(uop_vfirst), vt);
        chk("R1", "base", int'(uop_base), int'(w[9:5]));
        chk("R1", "offreg", int'(uop_offreg), rm);
        chk("R1", "pred", int'(uop_pred), int'(w[12:10]));
        chk("R1", "esize", int'(uop_esize), int'(w[24:23]));
    endtask

    task automatic run_instr(input bit st, input bit immf, input logic [31:0] w, input int tag);
        int code, total;
        code  = int'(w[22:21]);
        total = ((code != 0) && (immf || w[20:16] != 5'd31)) ? 2 * (code + 1) : 1;
        @(negedge clk);
        chk("R10", "in_ready idle", int'(in_ready), 1);
        in_valid = 1'b1; in_word = w; in_store = st; in_imm_form = immf; uop_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < total; k++) begin
            if (((k + tag) % 3) == 0) begin
                uop_ready = 1'b0;
                // offered while busy: must be ignored (R10)
                in_valid = 1'b1; in_word = ~w; in_store = ~st; in_imm_form = ~immf;
                chk_uop(st, immf, w, k);
                chk("R10", "in_ready busy", int'(in_ready), 0);
                @(posedge clk);
                @(negedge clk);
                in_valid = 1'b0;
                chk_uop(st, immf, w, k);
            end
            uop_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (k == total - 1) begin
                chk("R5", "valid after last", int'(uop_valid), 0);
                chk("R10", "in_ready after last", int'(in_ready), 1);
            end else begin
                chk_uop(st, immf, w, k + 1);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int tag;
        logic [31:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "in_ready after reset", int'(in_ready), 1);
        chk("R11", "uop_valid after reset", int'(uop_valid), 0);
        tag = 0;
        for (int st = 0; st < 2; st++)
            for (int immf = 0; immf < 2; immf++)
                for (int code = 0; code < 4; code++)
                    for (int vi = 0; vi < 3; vi++)
                        for (int o = 0; o < (immf != 0 ? 16 : 3); o++) begin
                            w = '0;
                            w[4:0]   = (vi == 0) ? 5'd0 : (vi == 1) ? 5'd30 : 5'd31;
                            w[9:5]   = 5'((tag * 7) % 32);
                            w[12:10] = 3'(tag % 8);
                            if (immf != 0) begin
                                w[19:16] = 4'(o);
                                w[20]    = 1'(tag % 2);
                            end else begin
                                w[20:16] = (o == 0) ? 5'd0 : (o == 1) ? 5'd17 : 5'd31;
                            end
                            w[22:21] = 2'(code);
                            w[24:23] = 2'(tag % 4);
                            w[31:25] = 7'(tag);
                            run_instr(st[0], immf[0], w, tag);
                            tag++;
                        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule